// File: doc/BRIEF.md
# Serial Command Receiver for a Four-Digit Display Controller

This block takes 16-bit commands from a three-wire serial link (serial clock, data and a load strobe) and writes them into the register file of a four-digit display controller. The serial inputs are brought into the core clock domain and edge-detected there. Data is shifted in on each rising serial-clock edge. The word is committed to the addressed register when the load strobe rises. A delayed copy of the serial stream is driven out on `ser_dout`, so several controllers can be chained on one link. The word's address nibble selects one of these registers:

- four digit registers;
- a per-digit decode-enable mask;
- intensity;
- scan limit;
- the run/shutdown bit;
- a feature register;
- a display-test bit.

A shutdown write can also clear the feature register. A register-reset feature bit returns the control registers to their power-up values and leaves the digit registers alone.

Command handling is a four-state machine:

- **S_IDLE**: the strobe is high. A falling strobe moves it to S_SHIFT. A rising strobe moves it to S_COMMIT.
- **S_SHIFT**: the strobe is low. A rising strobe moves it to S_COMMIT.
- **S_COMMIT**: lasts one cycle and writes the captured word. If that word set the register-reset bit, the machine goes to S_SOFTRST. Otherwise it goes to S_SHIFT if the strobe has fallen again, and to S_IDLE if it has not.
- **S_SOFTRST**: lasts one cycle, clears the control registers, then goes to S_SHIFT or S_IDLE by the same rule.

The word is captured from the shift register in the cycle in which the strobe rise is seen.

Top module: `disp_cmd_rx`

## Requirements
- R1: Commands are 16 bits sent most significant bit first. Bits 15..12 are ignored, bits 11..8 are the address and bits 7..0 are the data. Addresses 1, 2, 3 and 4 write the digit registers 0, 1, 2 and 3, and `digit_data[8*i+7:8*i]` holds digit i.
- R2: A register changes only after a rising edge of `ser_load`. Each rising edge commits exactly one word.
- R3: If fewer than 16 serial clocks arrive before the strobe rises, the word committed is the current content of the 16-bit shift register: the older bits, moved up by the number of new bits.
- R4: Each bit shifted in appears on `ser_dout` after the falling serial-clock edge that follows the sixteenth later rising edge. It is held until the next falling edge.
- R5: When feature bit 3 is 1, serial-clock edges are shifted in only while `ser_load` is low. When feature bit 3 is 0, they are shifted in whatever the level of `ser_load`.
- R6: After `rst_n` all outputs are zero: digits, decode mask, intensity, scan limit (one digit), run (shutdown), feature, display test and `ser_dout`.
- R7: Writes to address 0 (no-op), to addresses 5 to 8 and to address 13 change no register.
- R8: A write to address 12 sets `run_en` from data bit 0. If data bit 7 is 0 it also clears the feature register; if bit 7 is 1 the feature register is kept.
- R9: Writing the feature register (address 14) with data bit 1 set returns the decode mask, intensity, scan limit, run and display-test registers to zero. The feature register keeps the written value and the digit registers keep their contents.
- R10: The data fields are placed as follows. Address 9 takes decode mask bit i from data bit i. Address 10 takes intensity from data bits 3..0. Address 11 takes the scan limit from data bits 2..0. Address 15 takes display test from data bit 0. Address 14 takes all 8 data bits into `feature`.
- R11: A serial-clock rising edge seen in the same core cycle as the strobe rise is not part of the committed word. When feature bit 3 is 0, that bit stays in the shift register for the next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_din | input | 1 | Serial data in |
| ser_load | input | 1 | Load / chip-select strobe; commit on rising edge |
| ser_dout | output | 1 | Delayed serial data for the next device in a chain |
| digit_data | output | 32 | Four 8-bit digit registers, digit 0 in the low byte |
| decode_en | output | 4 | Per-digit decode enable |
| intensity | output | 4 | Brightness step |
| scan_limit | output | 3 | Index of the highest scanned digit |
| run_en | output | 1 | 1 = normal operation, 0 = shutdown |
| feature | output | 8 | Feature register (bit 1 register reset, bit 3 strobe-gated clock) |
| test_en | output | 1 | Display-test mode |

## Verification
A serial-clock rising edge and a strobe rise can fall in the same core cycle. The shift and the commit then both act on the shift register at one edge. The bench raises `ser_clk` and `ser_load` at the same instant after fifteen data bits, so both pass through the same synchronizer stages. It expects the committed word to be the contents from before that sixteenth edge. A following strobe pulse with no clocks must then commit the word that includes the coincident bit, which shows that the bit was kept rather than dropped.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADR_NOOP   = 4'h0;
    localparam logic [ADDR_W-1:0] ADR_DECODE = 4'h9;
    localparam logic [ADDR_W-1:0] ADR_INTENS = 4'hA;
    localparam logic [ADDR_W-1:0] ADR_SCAN   = 4'hB;
    localparam logic [ADDR_W-1:0] ADR_SHDN   = 4'hC;
    localparam logic [ADDR_W-1:0] ADR_SPARE  = 4'hD;
    localparam logic [ADDR_W-1:0] ADR_FEAT   = 4'hE;
    localparam logic [ADDR_W-1:0] ADR_TEST   = 4'hF;

    localparam int FEAT_REGRES  = 1;
    localparam int FEAT_GATED   = 3;
    localparam int SHDN_KEEP    = 7;
    localparam int SHDN_RUN     = 0;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_SHIFT   = 2'd1,
        S_COMMIT  = 2'd2,
        S_SOFTRST = 2'd3
    } rx_state_e;

endpackage

// File: rtl/disp_cmd_sync.sv
module disp_cmd_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= async_in;
                end else begin
                    stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/disp_cmd_shift.sv
module disp_cmd_shift #(
    parameter int WORD_W = 16,
    parameter int CMD_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             gate_open,
    input  logic             din,
    output logic [CMD_W-1:0] cmd_bits,
    output logic             dout
);

    logic [WORD_W-1:0] sr_q;
    logic              spill_q;
    logic              dout_q;
    logic              shift_en;

    assign shift_en = sclk_rise && gate_open;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q    <= '0;
            spill_q <= 1'b0;
        end else if (shift_en) begin
            sr_q    <= {sr_q[WORD_W-2:0], din};
            spill_q <= sr_q[WORD_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
        end else if (sclk_fall) begin
            dout_q <= spill_q;
        end
    end

    assign cmd_bits = sr_q[CMD_W-1:0];
    assign dout     = dout_q;

    // R5: a closed gate leaves the shift register untouched
    assert_gate_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && !gate_open) |=> $stable(sr_q));

    // R4: the chain output moves only after a falling serial edge
    assert_dout_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(dout_q));

endmodule

// File: rtl/disp_cmd_fsm.sv
module disp_cmd_fsm
    import disp_cmd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CMD_W  = ADDR_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_rise,
    input  logic              load_fall,
    input  logic [CMD_W-1:0]  cmd_bits,
    output logic              wr_en,
    output logic              srst_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    rx_state_e        state_q, state_d;
    logic [CMD_W-1:0] cmd_q;
    logic             regres_hit;

    assign wr_addr    = cmd_q[CMD_W-1 -: ADDR_W];
    assign wr_data    = cmd_q[DATA_W-1:0];
    assign regres_hit = (wr_addr == ADR_FEAT) && wr_data[FEAT_REGRES];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (load_rise)      state_d = S_COMMIT;
                else if (load_fall) state_d = S_SHIFT;
            end
            S_SHIFT: begin
                if (load_rise)      state_d = S_COMMIT;
            end
            S_COMMIT: begin
                if (regres_hit)     state_d = S_SOFTRST;
                else if (load_fall) state_d = S_SHIFT;
                else                state_d = S_IDLE;
            end
            S_SOFTRST: begin
                if (load_fall)      state_d = S_SHIFT;
                else                state_d = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (load_rise && (state_q == S_IDLE || state_q == S_SHIFT)) begin
            cmd_q <= cmd_bits;
        end
    end

    always_comb begin
        wr_en   = (state_q == S_COMMIT);
        srst_en = (state_q == S_SOFTRST);
    end

    // R9: the control reset happens only right after a commit
    assert_softrst_after_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        srst_en |-> $past(wr_en));

endmodule

// File: rtl/disp_cmd_regs.sv
module disp_cmd_regs
    import disp_cmd_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    parameter int DATA_W     = 8,
    parameter int INT_W      = 4,
    parameter int SCAN_W     = 3,
    localparam int DIG_BITS  = NUM_DIGITS * DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  srst_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [DIG_BITS-1:0]   digit_data,
    output logic [NUM_DIGITS-1:0] decode_en,
    output logic [INT_W-1:0]      intensity,
    output logic [SCAN_W-1:0]     scan_limit,
    output logic                  run_en,
    output logic [DATA_W-1:0]     feature,
    output logic                  test_en
);

    logic [DATA_W-1:0]     dig_q [NUM_DIGITS];
    logic [NUM_DIGITS-1:0] dec_q;
    logic [INT_W-1:0]      int_q;
    logic [SCAN_W-1:0]     scan_q;
    logic                  run_q;
    logic                  test_q;
    logic [DATA_W-1:0]     feat_q;

    generate
        for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dig_q[i] <= '0;
                end else if (wr_en && wr_addr == ADDR_W'(i + 1)) begin
                    dig_q[i] <= wr_data;
                end
            end
            assign digit_data[i*DATA_W +: DATA_W] = dig_q[i];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q  <= '0;
            int_q  <= '0;
            scan_q <= '0;
            run_q  <= 1'b0;
            test_q <= 1'b0;
        end else if (srst_en) begin
            dec_q  <= '0;
            int_q  <= '0;
            scan_q <= '0;
            run_q  <= 1'b0;
            test_q <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_DECODE: dec_q  <= wr_data[NUM_DIGITS-1:0];
                ADR_INTENS: int_q  <= wr_data[INT_W-1:0];
                ADR_SCAN:   scan_q <= wr_data[SCAN_W-1:0];
                ADR_SHDN:   run_q  <= wr_data[SHDN_RUN];
                ADR_TEST:   test_q <= wr_data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            feat_q <= '0;
        end else if (wr_en && wr_addr == ADR_FEAT) begin
            feat_q <= wr_data;
        end else if (wr_en && wr_addr == ADR_SHDN && !wr_data[SHDN_KEEP]) begin
            feat_q <= '0;
        end
    end

    assign decode_en  = dec_q;
    assign intensity  = int_q;
    assign scan_limit = scan_q;
    assign run_en     = run_q;
    assign test_en    = test_q;
    assign feature    = feat_q;

    // R2: no register moves without a commit or a control reset
    assert_hold_without_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !srst_en) |=> $stable({digit_data, dec_q, int_q, scan_q, run_q, test_q, feat_q}));

    // R7: no-op and unused addresses leave every register unchanged
    assert_ignored_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !srst_en && (wr_addr == ADR_NOOP || wr_addr == ADR_SPARE ||
            (wr_addr > ADDR_W'(NUM_DIGITS) && wr_addr < ADR_DECODE)))
        |=> $stable({digit_data, dec_q, int_q, scan_q, run_q, test_q, feat_q}));

    // R8: shutdown write with bit 7 low clears the feature register
    assert_shdn_clears_feature_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_SHDN && !wr_data[SHDN_KEEP]) |=> (feat_q == '0));

    // R8: shutdown write with bit 7 high keeps the feature register
    assert_shdn_keeps_feature_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_SHDN && wr_data[SHDN_KEEP]) |=> $stable(feat_q));

    // R9: the control reset clears controls and spares the digits and features
    assert_softrst_scope_R9: assert property (@(posedge clk) disable iff (!rst_n)
        srst_en |=> ($stable({digit_data, feat_q}) && dec_q == '0 && int_q == '0 &&
                     scan_q == '0 && !run_q && !test_q));

endmodule

// File: rtl/disp_cmd_rx.sv
module disp_cmd_rx
    import disp_cmd_pkg::*;
#(
    parameter int NUM_DIGITS  = 4,
    parameter int DATA_W      = 8,
    parameter int WORD_W      = 16,
    parameter int INT_W       = 4,
    parameter int SCAN_W      = 3,
    parameter int SYNC_STAGES = 2,
    localparam int CMD_W      = ADDR_W + DATA_W,
    localparam int DIG_BITS   = NUM_DIGITS * DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_clk,
    input  logic                  ser_din,
    input  logic                  ser_load,
    output logic                  ser_dout,
    output logic [DIG_BITS-1:0]   digit_data,
    output logic [NUM_DIGITS-1:0] decode_en,
    output logic [INT_W-1:0]      intensity,
    output logic [SCAN_W-1:0]     scan_limit,
    output logic                  run_en,
    output logic [DATA_W-1:0]     feature,
    output logic                  test_en
);

    logic [2:0]        sync_v;
    logic              load_s, sclk_s, din_s;
    logic              load_d, sclk_d;
    logic              sclk_rise, sclk_fall, load_rise, load_fall;
    logic              gate_open;
    logic [CMD_W-1:0]  cmd_bits;
    logic              wr_en, srst_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    disp_cmd_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_load, ser_clk, ser_din}),
        .sync_out (sync_v)
    );

    assign {load_s, sclk_s, din_s} = sync_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_d <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            load_d <= load_s;
            sclk_d <= sclk_s;
        end
    end

    assign sclk_rise = sclk_s && !sclk_d;
    assign sclk_fall = !sclk_s && sclk_d;
    assign load_rise = load_s && !load_d;
    assign load_fall = !load_s && load_d;
    assign gate_open = !feature[FEAT_GATED] || !load_s;

    disp_cmd_shift #(
        .WORD_W (WORD_W),
        .CMD_W  (CMD_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .gate_open (gate_open),
        .din       (din_s),
        .cmd_bits  (cmd_bits),
        .dout      (ser_dout)
    );

    disp_cmd_fsm #(
        .DATA_W (DATA_W),
        .CMD_W  (CMD_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_rise (load_rise),
        .load_fall (load_fall),
        .cmd_bits  (cmd_bits),
        .wr_en     (wr_en),
        .srst_en   (srst_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    disp_cmd_regs #(
        .NUM_DIGITS (NUM_DIGITS),
        .DATA_W     (DATA_W),
        .INT_W      (INT_W),
        .SCAN_W     (SCAN_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .srst_en    (srst_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .digit_data (digit_data),
        .decode_en  (decode_en),
        .intensity  (intensity),
        .scan_limit (scan_limit),
        .run_en     (run_en),
        .feature    (feature),
        .test_en    (test_en)
    );

    // R2: every detected strobe rise leads to a commit cycle
    assert_rise_commits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_rise && !wr_en && !srst_en) |=> wr_en);

endmodule

// File: tb/disp_cmd_rx_tb.sv
module disp_cmd_rx_tb;

    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_din = 1'b0;
    logic        ser_load = 1'b1;
    logic        ser_dout;
    logic [31:0] digit_data;
    logic [3:0]  decode_en;
    logic [3:0]  intensity;
    logic [2:0]  scan_limit;
    logic        run_en;
    logic [7:0]  feature;
    logic        test_en;

    always #2 clk = ~clk;

    disp_cmd_rx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk    (ser_clk),
        .ser_din    (ser_din),
        .ser_load   (ser_load),
        .ser_dout   (ser_dout),
        .digit_data (digit_data),
        .decode_en  (decode_en),
        .intensity  (intensity),
        .scan_limit (scan_limit),
        .run_en     (run_en),
        .feature    (feature),
        .test_en    (test_en)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sbq[$];

    logic [7:0]  m_dig [4];
    logic [3:0]  m_dec;
    logic [3:0]  m_int;
    logic [2:0]  m_scan;
    logic        m_run;
    logic [7:0]  m_feat;
    logic        m_test;
    logic [15:0] msr;

    function automatic logic [7:0] observe(input int kind);
        case (kind)
            0, 1, 2, 3: return digit_data[kind*8 +: 8];
            4:  return {4'h0, decode_en};
            5:  return {4'h0, intensity};
            6:  return {5'h0, scan_limit};
            7:  return {7'h0, run_en};
            8:  return feature;
            9:  return {7'h0, test_en};
            default: return {7'h0, ser_dout};
        endcase
    endfunction

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            while (sbq.size() > 0) begin
                item_t it;
                logic [7:0] got;
                it  = sbq.pop_front();
                got = observe(it.kind);
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s item %0d actual=%02h expected=%02h", it.req, it.kind, got, it.exp);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_item(input int kind, input logic [7:0] exp, input string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        sbq.push_back(it);
        tick(2);
    endtask

    task automatic expect_all(input string req);
        for (int i = 0; i < 4; i++) expect_item(i, m_dig[i], req);
        expect_item(4, {4'h0, m_dec}, req);
        expect_item(5, {4'h0, m_int}, req);
        expect_item(6, {5'h0, m_scan}, req);
        expect_item(7, {7'h0, m_run}, req);
        expect_item(8, m_feat, req);
        expect_item(9, {7'h0, m_test}, req);
    endtask

    task automatic model_commit(input logic [15:0] w);
        logic [3:0] a;
        logic [7:0] d;
        a = w[11:8];
        d = w[7:0];
        case (a)
            4'h1, 4'h2, 4'h3, 4'h4: m_dig[a - 4'h1] = d;
            4'h9: m_dec  = d[3:0];
            4'hA: m_int  = d[3:0];
            4'hB: m_scan = d[2:0];
            4'hC: begin m_run = d[0]; if (!d[7]) m_feat = 8'h00; end
            4'hE: begin
                m_feat = d;
                if (d[1]) begin
                    m_dec = 0; m_int = 0; m_scan = 0; m_run = 0; m_test = 0;
                end
            end
            4'hF: m_test = d[0];
            default: ;
        endcase
    endtask

    task automatic sclk_pulse(input logic b);
        ser_din = b;
        tick(HALF);
        ser_clk = 1'b1;
        if (!m_feat[3] || !ser_load) msr = {msr[14:0], b};
        tick(HALF);
        ser_clk = 1'b0;
    endtask

    task automatic load_pulse();
        ser_load = 1'b0;
        tick(HALF);
        ser_load = 1'b1;
        model_commit(msr);
        tick(12);
    endtask

    task automatic send(input logic [15:0] w, input int nbits);
        ser_load = 1'b0;
        tick(HALF);
        for (int i = nbits - 1; i >= 0; i--) sclk_pulse(w[i]);
        tick(HALF);
        ser_load = 1'b1;
        model_commit(msr);
        tick(12);
    endtask

    initial begin
        logic [31:0] pat;
        logic [15:0] snap;
        logic [15:0] w;
        for (int i = 0; i < 4; i++) m_dig[i] = 8'h00;
        m_dec = 0; m_int = 0; m_scan = 0; m_run = 0; m_feat = 0; m_test = 0; msr = 0;
        tick(5);
        rst_n = 1'b1;
        tick(4);

        // R6: power-up values
        expect_all("R6");
        expect_item(10, 8'h00, "R6");

        // R1: address and data fields, high nibble ignored
        send(16'hF13A, 16);
        send(16'h9242, 16);
        send(16'h5387, 16);
        send(16'hC4E1, 16);
        expect_all("R1");

        // R10: control field placement
        send(16'h09A5, 16);
        send(16'h0A3C, 16);
        send(16'h0B7E, 16);
        send(16'h0F03, 16);
        expect_all("R10");

        // R8: shutdown write, keep then clear feature
        send(16'h0EF4, 16);
        send(16'h0C81, 16);
        expect_all("R8");
        send(16'h0C00, 16);
        expect_all("R8");
        send(16'h0E30, 16);
        send(16'h0C01, 16);
        expect_all("R8");

        // R7: no-op and unused addresses
        send(16'h00FF, 16);
        send(16'h05FF, 16);
        send(16'h08FF, 16);
        send(16'h0DFF, 16);
        expect_all("R7");

        // R3: short word commits shifted contents
        send(16'h005A, 8);
        expect_all("R3");

        // R5: strobe-gated mode ignores clocks while the strobe is high
        send(16'h0E08, 16);
        for (int i = 11; i >= 0; i--) sclk_pulse(w_bit(12'h3C1, i));
        load_pulse();
        expect_all("R5");
        send(16'h03C1, 12);
        expect_all("R5");
        send(16'h0C01, 16);
        for (int i = 11; i >= 0; i--) sclk_pulse(w_bit(12'h4D2, i));
        load_pulse();
        expect_all("R5");

        // R9: register reset keeps digits and feature
        send(16'h0F01, 16);
        send(16'h0E02, 16);
        expect_all("R9");
        send(16'h0A07, 16);
        send(16'h0C00, 16);
        expect_all("R9");

        // R4: daisy-chain output timing
        pat = 32'hB7A6_70C3;
        ser_load = 1'b0;
        tick(HALF);
        for (int j = 0; j < 32; j++) begin
            ser_din = pat[31-j];
            tick(HALF);
            ser_clk = 1'b1;
            msr = {msr[14:0], pat[31-j]};
            tick(HALF);
            ser_clk = 1'b0;
            tick(5);
            if (j >= 16) expect_item(10, {7'h0, pat[31-(j-16)]}, "R4");
        end
        tick(HALF);
        ser_load = 1'b1;
        model_commit(msr);
        tick(12);
        expect_all("R4");

        // R11: clock edge coincident with strobe rise
        w = 16'h0299;
        ser_load = 1'b0;
        tick(HALF);
        for (int i = 15; i >= 1; i--) sclk_pulse(w[i]);
        ser_din = w[0];
        tick(HALF);
        snap = msr;
        ser_clk = 1'b1;
        ser_load = 1'b1;
        msr = {msr[14:0], w[0]};
        model_commit(snap);
        tick(HALF);
        ser_clk = 1'b0;
        tick(12);
        expect_all("R11");
        load_pulse();
        expect_all("R11");

        tick(4);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic w_bit(input logic [11:0] v, input int i);
        return v[i];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL all requirements: watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule